// File: doc/BRIEF.md
# Watchpoint Counter Trap Generator

This block turns load/store watchpoint match strobes into breakpoint trap requests for the core. Each watchpoint has its own enable. When that enable is set, every match of the watchpoint raises a trap. The block also has a small set of countdown counters. Software loads a counter with a count n and picks which watchpoint decrements it. The counter then raises a single trap on the n-th selected match, and does nothing more until it is loaded again.

Every trap that is raised carries two attributes taken from configuration. The first is a nonmaskable flag, which lets the trap through even while maskable interrupts are disabled. The second is a route flag, which sends the trap either to the regular exception path or to debug-mode entry. A maskable trap that arrives while interrupts are masked is held as a single pending request and is issued once the mask lifts. All trap sources that fire in the same cycle merge into one request. The address comparators that produce the match strobes, and the exception logic that consumes the request, sit outside this block.

Top module: `wp_trap_gen`

## Requirements
- R1: A match on watchpoint i (`wp_match[i]`=1) while `every_en[i]`=1, sampled on a rising edge at which the trap can be taken, makes `trap_req`=1 for the cycle after that edge. A match on a watchpoint whose enable is 0 raises no trap by itself.
- R2: A 1 on `cnt_load[k]` at an edge loads counter k with its slice `cnt_load_val[k*CNT_W +: CNT_W]`. If a match for that counter arrives in the same cycle, the load wins and the match is not counted.
- R3: Counter k decrements only on a match of the watchpoint whose index equals its select field `cnt_sel[k*SEL_W +: SEL_W]`. A select value of NUM_WP or above selects no watchpoint, so the counter never moves.
- R4: A counter raises exactly one trap event, on the selected match that takes it from 1 to 0. At 0 it holds and never wraps, so later matches raise nothing. A counter loaded with 0 never fires.
- R5: Any number of trap sources (per-match enables and counters) firing in the same cycle produce a single one-cycle trap request.
- R6: While `nonmask_cfg`=1, a trap event is issued on the next cycle whatever the value of `int_en`.
- R7: While `nonmask_cfg`=0 and `int_en`=0, `trap_req` stays 0 and trap events are held as one pending request. The pending request is issued as a single pulse on the cycle after the first edge at which `int_en` or `nonmask_cfg` is 1.
- R8: When `trap_req`=1, `trap_to_debug` and `trap_nonmask` equal `dbg_route_en` and `nonmask_cfg` as sampled at the issuing edge. When `trap_req`=0, both are 0.
- R9: A synchronous reset (`rst_n`=0 at an edge) clears all counters, the pending request and all outputs. After reset, no trap fires until a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_match | input | NUM_WP | Load/store watchpoint match strobes, one per watchpoint |
| every_en | input | NUM_WP | Per-watchpoint enable for trapping on every match |
| cnt_load | input | NUM_CNT | Load strobe for each countdown counter |
| cnt_load_val | input | NUM_CNT*CNT_W | Load value for each counter, packed by counter index |
| cnt_sel | input | NUM_CNT*SEL_W | Watchpoint select for each counter, packed by counter index |
| nonmask_cfg | input | 1 | 1 makes breakpoint traps nonmaskable |
| int_en | input | 1 | Maskable interrupts currently enabled |
| dbg_route_en | input | 1 | 1 routes traps to debug entry, 0 to the exception path |
| trap_req | output | 1 | Trap request, one cycle per issued trap |
| trap_nonmask | output | 1 | Issued trap is nonmaskable |
| trap_to_debug | output | 1 | Issued trap enters debug mode |

## Verification
The bench targets the cases where a counter design usually slips:
- a load that collides with a match, which a flawed design would count, so the trap fires one match early;
- a counter sitting at zero, which a wrapping design would decrement back to its maximum;
- an out-of-range select, which a design that indexes the match vector without a range check would map onto a real watchpoint.

On the masking side, it holds several events while masked and then unmasks. A wrong design would either drop the pending request or issue it more than once. It also changes the route between the event and the release; a design that latched the attributes at event time would report the stale route. Finally, it resets while a request is pending and while a counter is loaded. A flawed reset would let a trap leak out afterwards.

// File: rtl/wpt_pkg.sv
// Package: shared types for the watchpoint trap generator.
// Assumes: attributes are only meaningful while a trap is issued.
package wpt_pkg;

    // Class attached to an issued trap
    typedef struct packed {
        logic nonmask;
        logic to_debug;
    } trap_attr_t;

    // Build the attribute word, forced to zero when no trap issues
    function automatic trap_attr_t mk_attr(input logic issue,
                                           input logic nonmask,
                                           input logic to_debug);
        trap_attr_t a;
        a.nonmask  = issue & nonmask;
        a.to_debug = issue & to_debug;
        return a;
    endfunction

endpackage

// File: rtl/wpt_every_src.sv
// Module: per-match trap source.
// Merges watchpoint strobes gated by their own enables into one event.
// Assumes: strobes are single-cycle pulses already synchronous to clk.
module wpt_every_src #(
    parameter int NUM_WP = 4
) (
    input  logic [NUM_WP-1:0] wp_match,
    input  logic [NUM_WP-1:0] every_en,
    output logic              every_hit
);

    // Any enabled watchpoint that matched this cycle
    always_comb begin
        every_hit = |(wp_match & every_en);
    end

endmodule

// File: rtl/wpt_countdown.sv
// Module: one countdown trap counter.
// Loads a count, decrements on matches of its selected watchpoint,
// pulses fire on the 1->0 step and then idles at zero (no wrap).
// Assumes: select values at or above NUM_WP match nothing.
module wpt_countdown #(
    parameter int NUM_WP = 4,
    parameter int CNT_W  = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] wp_match,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [SEL_W-1:0]  sel,
    output logic              fire,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [NUM_WP-1:0] sel_vec;
    logic              sel_hit;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  count_d;

    // Decode the select field into a one-hot watchpoint mask
    for (genvar i = 0; i < NUM_WP; i++) begin : g_dec
        assign sel_vec[i] = (sel == SEL_W'(i));
    end

    // Match on the selected watchpoint, none when out of range
    always_comb begin
        sel_hit = |(sel_vec & wp_match);
    end

    // Next count and the fire pulse; load has priority over counting
    always_comb begin
        count_d = count_q;
        fire    = 1'b0;
        if (load) begin
            count_d = load_val;
        end else if ((count_q != '0) && sel_hit) begin
            count_d = count_q - ONE;
            fire    = (count_q == ONE);
        end
    end

    // Count register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/wpt_issue.sv
// Module: trap issue stage.
// Applies the maskable/nonmaskable policy, holds one pending request
// while masked, and registers the request with its class attributes.
// Assumes: event_in may be high several cycles; held events merge.
module wpt_issue
    import wpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    input  logic nonmask_cfg,
    input  logic int_en,
    input  logic dbg_route_en,
    output logic trap_req,
    output logic trap_nonmask,
    output logic trap_to_debug,
    output logic pend
);

    logic       pend_q;
    logic       req_q;
    trap_attr_t attr_q;
    logic       take;
    logic       want;
    trap_attr_t attr_d;

    // Decide whether a trap can be taken now and whether one is wanted
    always_comb begin
        take   = nonmask_cfg | int_en;
        want   = event_in | pend_q;
        attr_d = mk_attr(want & take, nonmask_cfg, dbg_route_en);
    end

    // Pending flag and registered request with attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            req_q  <= 1'b0;
            attr_q <= '0;
        end else begin
            pend_q <= want & ~take;
            req_q  <= want & take;
            attr_q <= attr_d;
        end
    end

    assign trap_req      = req_q;
    assign trap_nonmask  = attr_q.nonmask;
    assign trap_to_debug = attr_q.to_debug;
    assign pend          = pend_q;

endmodule

// File: rtl/wp_trap_gen.sv
// Module: watchpoint counter trap generator (top).
// Combines per-match sources and NUM_CNT countdown counters into one
// trap event, then issues it through the mask/route stage.
// Assumes: configuration inputs are held stable by their owner.
module wp_trap_gen #(
    parameter int NUM_WP  = 4,
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 8,
    localparam int SEL_W  = $clog2(NUM_WP) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_WP-1:0]        wp_match,
    input  logic [NUM_WP-1:0]        every_en,
    input  logic [NUM_CNT-1:0]       cnt_load,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_load_val,
    input  logic [NUM_CNT*SEL_W-1:0] cnt_sel,
    input  logic                     nonmask_cfg,
    input  logic                     int_en,
    input  logic                     dbg_route_en,
    output logic                     trap_req,
    output logic                     trap_nonmask,
    output logic                     trap_to_debug
);

    logic                     every_hit;
    logic [NUM_CNT-1:0]       cnt_fire;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic                     raw_evt;
    logic                     pend;

    wpt_every_src #(.NUM_WP(NUM_WP)) u_every (
        .wp_match  (wp_match),
        .every_en  (every_en),
        .every_hit (every_hit)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        wpt_countdown #(
            .NUM_WP (NUM_WP),
            .CNT_W  (CNT_W),
            .SEL_W  (SEL_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .wp_match (wp_match),
            .load     (cnt_load[k]),
            .load_val (cnt_load_val[k*CNT_W +: CNT_W]),
            .sel      (cnt_sel[k*SEL_W +: SEL_W]),
            .fire     (cnt_fire[k]),
            .count    (cnt_flat[k*CNT_W +: CNT_W])
        );
    end

    // All sources of this cycle merge into one event
    always_comb begin
        raw_evt = every_hit | (|cnt_fire);
    end

    wpt_issue u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_in      (raw_evt),
        .nonmask_cfg   (nonmask_cfg),
        .int_en        (int_en),
        .dbg_route_en  (dbg_route_en),
        .trap_req      (trap_req),
        .trap_nonmask  (trap_nonmask),
        .trap_to_debug (trap_to_debug),
        .pend          (pend)
    );

endmodule

// File: rtl/wp_trap_gen_chk.sv
// Module: property checker for wp_trap_gen, attached by bind.
// Assumes: connected to the top's ports and its internal counter,
// fire, event and pending signals.
module wp_trap_gen_chk #(
    parameter int NUM_WP  = 4,
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 8,
    parameter int SEL_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_WP-1:0]        wp_match,
    input logic [NUM_WP-1:0]        every_en,
    input logic [NUM_CNT-1:0]       cnt_load,
    input logic [NUM_CNT*CNT_W-1:0] cnt_load_val,
    input logic [NUM_CNT*SEL_W-1:0] cnt_sel,
    input logic                     nonmask_cfg,
    input logic                     int_en,
    input logic                     dbg_route_en,
    input logic                     trap_req,
    input logic                     trap_nonmask,
    input logic                     trap_to_debug,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]       cnt_fire,
    input logic                     raw_evt,
    input logic                     pend
);

    // Independent decode of a select field against the strobes
    function automatic logic sel_match(input logic [SEL_W-1:0] s,
                                       input logic [NUM_WP-1:0] m);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_WP; i++) begin
            if (s == SEL_W'(i)) r = r | m[i];
        end
        return r;
    endfunction

    assert_every_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((nonmask_cfg || int_en) && (|(wp_match & every_en))) |=> trap_req);

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_load[k] |=> (cnt_flat[k*CNT_W +: CNT_W] ==
                             $past(cnt_load_val[k*CNT_W +: CNT_W])));

        assert_hold_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_load[k] && !sel_match(cnt_sel[k*SEL_W +: SEL_W], wp_match))
            |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));

        assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt_flat[k*CNT_W +: CNT_W] == '0) && !cnt_load[k])
            |=> (cnt_flat[k*CNT_W +: CNT_W] == '0));

        assert_fire_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_fire[k] |=> (cnt_flat[k*CNT_W +: CNT_W] == '0));
    end

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !raw_evt) |=> !trap_req);

    assert_nonmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nonmask_cfg && raw_evt) |=> trap_req);

    assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonmask_cfg && !int_en) |=> !trap_req);

    assert_masked_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonmask_cfg && !int_en && raw_evt) |=> pend);

    assert_attr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((trap_to_debug == $past(dbg_route_en)) &&
                      (trap_nonmask == $past(nonmask_cfg))));

    assert_quiet_attr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (!trap_to_debug && !trap_nonmask));

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!trap_req && !pend && (cnt_flat == '0)));

endmodule

bind wp_trap_gen wp_trap_gen_chk #(
    .NUM_WP  (NUM_WP),
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp_match      (wp_match),
    .every_en      (every_en),
    .cnt_load      (cnt_load),
    .cnt_load_val  (cnt_load_val),
    .cnt_sel       (cnt_sel),
    .nonmask_cfg   (nonmask_cfg),
    .int_en        (int_en),
    .dbg_route_en  (dbg_route_en),
    .trap_req      (trap_req),
    .trap_nonmask  (trap_nonmask),
    .trap_to_debug (trap_to_debug),
    .cnt_flat      (cnt_flat),
    .cnt_fire      (cnt_fire),
    .raw_evt       (raw_evt),
    .pend          (pend)
);

// File: tb/wp_trap_gen_tb.sv
// Bench: behavioural reference model compared every cycle, plus
// directed checks at the cycle each trap is expected.
module wp_trap_gen_tb;

    localparam int NUM_WP  = 4;
    localparam int NUM_CNT = 2;
    localparam int CNT_W   = 8;
    localparam int SEL_W   = $clog2(NUM_WP) + 1;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NUM_WP-1:0]        wp_match;
    logic [NUM_WP-1:0]        every_en;
    logic [NUM_CNT-1:0]       cnt_load;
    logic [NUM_CNT*CNT_W-1:0] cnt_load_val;
    logic [NUM_CNT*SEL_W-1:0] cnt_sel;
    logic                     nonmask_cfg;
    logic                     int_en;
    logic                     dbg_route_en;
    logic                     trap_req;
    logic                     trap_nonmask;
    logic                     trap_to_debug;

    int    compared   = 0;
    int    mismatched = 0;
    int    cycles     = 0;
    bit    started    = 0;
    string phase      = "R9";

    // Reference model state
    int cnt_m [NUM_CNT];
    bit pend_m, exp_req, exp_nm, exp_dbg;

    always #10 clk = ~clk;

    wp_trap_gen #(.NUM_WP(NUM_WP), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_match(wp_match), .every_en(every_en),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_sel(cnt_sel),
        .nonmask_cfg(nonmask_cfg), .int_en(int_en), .dbg_route_en(dbg_route_en),
        .trap_req(trap_req), .trap_nonmask(trap_nonmask),
        .trap_to_debug(trap_to_debug)
    );

    // Reference model: advances on each rising edge from the requirements
    always @(posedge clk) begin
        bit evt;
        started = 1;
        if (!rst_n) begin
            foreach (cnt_m[k]) cnt_m[k] = 0;
            pend_m = 0; exp_req = 0; exp_nm = 0; exp_dbg = 0;
        end else begin
            evt = |(wp_match & every_en);
            for (int k = 0; k < NUM_CNT; k++) begin
                int s;
                bit hit;
                s   = int'(cnt_sel[k*SEL_W +: SEL_W]);
                hit = (s < NUM_WP) ? wp_match[s] : 1'b0;
                if (cnt_load[k]) cnt_m[k] = int'(cnt_load_val[k*CNT_W +: CNT_W]);
                else if (cnt_m[k] > 0 && hit) begin
                    if (cnt_m[k] == 1) evt = 1;
                    cnt_m[k] = cnt_m[k] - 1;
                end
            end
            if (nonmask_cfg || int_en) begin
                exp_req = evt || pend_m;
                pend_m  = 0;
            end else begin
                pend_m  = evt || pend_m;
                exp_req = 0;
            end
            exp_nm  = exp_req && nonmask_cfg;
            exp_dbg = exp_req && dbg_route_en;
        end
    end

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        if (started) begin
            compared++;
            if ({trap_req, trap_nonmask, trap_to_debug} !== {exp_req, exp_nm, exp_dbg}) begin
                mismatched++;
                $display("FAIL %s model compare: actual req/nm/dbg=%b%b%b expected=%b%b%b",
                         phase, trap_req, trap_nonmask, trap_to_debug,
                         exp_req, exp_nm, exp_dbg);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive a match pattern for one cycle; returns at the negedge
    // after the sampling edge, where the resulting trap is visible
    task automatic pulse(input logic [NUM_WP-1:0] m);
        wp_match = m;
        @(negedge clk);
        wp_match = '0;
    endtask

    task automatic load_cnt(input int k, input int val, input int sel);
        cnt_load[k] = 1'b1;
        cnt_load_val[k*CNT_W +: CNT_W] = CNT_W'(val);
        cnt_sel[k*SEL_W +: SEL_W] = SEL_W'(sel);
        @(negedge clk);
        cnt_load[k] = 1'b0;
    endtask

    initial begin
        rst_n = 0; wp_match = '0; every_en = '0; cnt_load = '0;
        cnt_load_val = '0; cnt_sel = '0; nonmask_cfg = 0; int_en = 0;
        dbg_route_en = 0;
        idle(3);
        chk("R9 reset output", trap_req, 1'b0);
        rst_n = 1; int_en = 1;
        idle(2);

        // R1: every-match enables
        phase = "R1";
        every_en = 4'b0010;
        pulse(4'b0010);
        chk("R1 enabled match traps", trap_req, 1'b1);
        idle(1);
        chk("R1 trap ends", trap_req, 1'b0);
        pulse(4'b0101);
        chk("R1 disabled match ignored", trap_req, 1'b0);
        every_en = '0;
        idle(1);

        // R3/R4: countdown of 3 on watchpoint 2
        phase = "R3";
        load_cnt(0, 3, 2);
        pulse(4'b1011);
        chk("R3 unselected match ignored", trap_req, 1'b0);
        pulse(4'b0100);
        pulse(4'b0100);
        chk("R4 no trap before count ends", trap_req, 1'b0);
        phase = "R4";
        pulse(4'b0100);
        chk("R4 trap on third selected match", trap_req, 1'b1);
        pulse(4'b0100);
        chk("R4 no wrap after zero", trap_req, 1'b0);
        load_cnt(0, 0, 2);
        pulse(4'b0100);
        chk("R4 zero load never fires", trap_req, 1'b0);

        // R2: load beats a concurrent match
        phase = "R2";
        wp_match = 4'b0100;
        load_cnt(0, 2, 2);
        wp_match = '0;
        pulse(4'b0100);
        chk("R2 colliding match not counted", trap_req, 1'b0);
        pulse(4'b0100);
        chk("R2 fires after full count", trap_req, 1'b1);

        // R3: out-of-range select matches nothing
        phase = "R3";
        load_cnt(1, 1, 5);
        pulse(4'b1111);
        chk("R3 out-of-range select idle", trap_req, 1'b0);
        load_cnt(1, 1, 0);
        pulse(4'b0001);
        chk("R3 counter 1 on watchpoint 0", trap_req, 1'b1);

        // R5: simultaneous sources merge
        phase = "R5";
        every_en = 4'b0011;
        load_cnt(0, 1, 0);
        load_cnt(1, 1, 1);
        pulse(4'b0011);
        chk("R5 merged trap issued", trap_req, 1'b1);
        idle(1);
        chk("R5 single cycle request", trap_req, 1'b0);
        every_en = '0;

        // R6: nonmaskable ignores the mask
        phase = "R6";
        int_en = 0; nonmask_cfg = 1; every_en = 4'b1000;
        pulse(4'b1000);
        chk("R6 nonmaskable taken", trap_req, 1'b1);
        chk("R6 class nonmaskable", trap_nonmask, 1'b1);
        nonmask_cfg = 0;
        idle(1);

        // R7/R8: held while masked, route sampled at issue
        phase = "R7";
        dbg_route_en = 0;
        pulse(4'b1000);
        chk("R7 masked trap held", trap_req, 1'b0);
        pulse(4'b1000);
        idle(3);
        chk("R7 still held", trap_req, 1'b0);
        dbg_route_en = 1;
        int_en = 1;
        idle(1);
        chk("R7 pending trap released", trap_req, 1'b1);
        phase = "R8";
        chk("R8 route sampled at issue", trap_to_debug, 1'b1);
        chk("R8 maskable class", trap_nonmask, 1'b0);
        phase = "R7";
        idle(1);
        chk("R7 held events merged", trap_req, 1'b0);
        phase = "R8";
        chk("R8 attributes low without trap", trap_to_debug, 1'b0);
        dbg_route_en = 0;

        // R9: reset drops pending request and counters
        phase = "R9";
        int_en = 0;
        pulse(4'b1000);
        load_cnt(0, 1, 3);
        rst_n = 0;
        idle(2);
        rst_n = 1; int_en = 1; every_en = '0;
        idle(1);
        chk("R9 pending cleared", trap_req, 1'b0);
        pulse(4'b1000);
        chk("R9 counter cleared", trap_req, 1'b0);
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule